// File: doc/BRIEF.md
# Down-Counting Tick Timer

The block is a periodic down-counter of parameterised width (24 bits by default) with four word registers at fixed byte offsets. When software enables it, the counter is loaded from the reload register. It then decrements on each selected tick. The tick is either every core clock cycle or only those cycles in which an external reference-tick enable is high.

A tick that arrives while the counter holds zero is a wrap. A wrap reloads the counter, raises a sticky count flag and, if interrupts are enabled, emits a one-cycle interrupt-request pulse. Software can restart the period at any time by writing any value to the current-value register. A reload value of zero turns the timer into a one-shot: the next wrap turns the timer off.

Register reads are combinational from the address. The read strobe is used only for the side effect of clearing the count flag when the control register is read. Writes take effect at the clock edge on which the write strobe is high.

Top module: `tick_timer`

## Requirements
- R1: Control register (offset 0x10) layout: bit 0 enable, bit 1 interrupt enable, bit 2 clock source (1 = core clock, 0 = reference tick), bit 16 count flag. All other bits read as 0. After reset the whole register reads 0.
- R2: A control write updates only bits [2:0]. It never sets or clears the count flag.
- R3: A read of the control register returns the current flag, and the flag is 0 afterwards. If a wrap occurs at the same edge, the flag stays set.
- R4: The reload register (offset 0x14) keeps write bits [23:0] and reads with bits [31:24] as zero. It resets to 0.
- R5: A control write that changes enable from 0 to 1 loads the counter from the reload register. While enable is 0, the current-value register (offset 0x18) reads 0 and the counter does not move.
- R6: With clock source 1, the counter steps on every enabled cycle. With clock source 0, it steps only on cycles where the reference-tick input is high.
- R7: A step at count zero reloads the counter, and a step at any other count decrements it, so the period is reload+1 steps.
- R8: Every wrap sets the count flag. If interrupt enable is 1, the interrupt output is high for exactly the one cycle after the wrap edge, and it is low at all other times.
- R9: Any write to the current-value register clears the count flag and, while enabled, reloads the counter from the reload register.
- R10: A wrap that occurs while the reload register holds 0 clears enable, unless a control write happens on the same edge.
- R11: The calibration register (offset 0x1C) reads the constant 10000. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects only) |
| regAddr | input | 8 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| refTick | input | 1 | Reference-tick enable |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The bench uses the default 24-bit counter but programs reload values of 0 to 5. This makes wraps, one-shot stops and flag races occur within a few dozen cycles. A sparse reference-tick pattern exercises the external clock source. A reload of 0xFFFFFFFF checks the masking of the upper bits. The remaining scenarios pit a control read and a current-value write against a wrap on the same edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_RELOAD = 8'h14;
  localparam logic [7:0] OFS_CUR    = 8'h18;
  localparam logic [7:0] OFS_CAL    = 8'h1C;

  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // copy reload into counter
    logic step;    // one count tick this cycle
    logic relWr;   // capture new reload value
  } tmr_cmd_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] relData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] reload,
  output logic             wrap,
  output logic             reloadZero
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic atZero;
  assign atZero     = (cnt == ZERO);
  assign reloadZero = (reload == ZERO);
  assign wrap       = cmd.step && atZero && !cmd.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= ZERO;
    end else if (cmd.load) begin
      cnt <= reload;
    end else if (cmd.step) begin
      cnt <= atZero ? reload : (cnt - ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reload <= ZERO;
    end else if (cmd.relWr) begin
      reload <= relData;
    end
  end

  // R5 counter holds when neither loaded nor stepped
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(cnt));
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 8,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              refTick,
  output logic              irqPulse,
  output tmr_cmd_t          cmd,
  output logic [CNT_W-1:0]  relData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  reload,
  input  logic              wrap,
  input  logic              reloadZero
);
  localparam int PAD_W = 32 - CNT_W;

  logic enable, intEn, srcCore, countFlag;
  logic selCtrl, selRel, selCur, selCal;
  logic wrCtrl, wrCur, rdCtrl, enRise, tickSel;

  assign selCtrl = (regAddr == ADDR_W'(OFS_CTRL));
  assign selRel  = (regAddr == ADDR_W'(OFS_RELOAD));
  assign selCur  = (regAddr == ADDR_W'(OFS_CUR));
  assign selCal  = (regAddr == ADDR_W'(OFS_CAL));

  assign wrCtrl = regWrEn && selCtrl;
  assign wrCur  = regWrEn && selCur;
  assign rdCtrl = regRdEn && selCtrl;
  assign enRise = wrCtrl && regWrData[BIT_EN] && !enable;

  assign tickSel   = srcCore ? 1'b1 : refTick;
  assign cmd.load  = enRise || (wrCur && enable);
  assign cmd.step  = enable && tickSel;
  assign cmd.relWr = regWrEn && selRel;
  assign relData   = regWrData[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      intEn   <= 1'b0;
      srcCore <= 1'b0;
    end else if (wrCtrl) begin
      enable  <= regWrData[BIT_EN];
      intEn   <= regWrData[BIT_IE];
      srcCore <= regWrData[BIT_SRC];
    end else if (wrap && reloadZero) begin
      enable  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countFlag <= 1'b0;
    end else if (wrap) begin
      countFlag <= 1'b1;
    end else if (rdCtrl || wrCur) begin
      countFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqPulse <= 1'b0;
    else       irqPulse <= wrap && intEn;
  end

  logic [31:0] ctrlWord;
  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_EN]   = enable;
    ctrlWord[BIT_IE]   = intEn;
    ctrlWord[BIT_SRC]  = srcCore;
    ctrlWord[BIT_FLAG] = countFlag;
  end

  always_comb begin
    if (selCtrl)     regRdData = ctrlWord;
    else if (selRel) regRdData = {{PAD_W{1'b0}}, reload};
    else if (selCur) regRdData = enable ? {{PAD_W{1'b0}}, cnt} : 32'd0;
    else if (selCal) regRdData = 32'(CAL_VALUE);
    else             regRdData = 32'd0;
  end

  // R3
  rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrl && !wrap) |=> !countFlag);
  // R9
  cur_wr_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCur && !wrap) |=> !countFlag);
  // R2
  ctrl_wr_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !wrap) |=> (countFlag == $past(countFlag)));
  // R8
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> countFlag);
  // R10
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && reloadZero && !wrCtrl) |=> !enable);
  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    enRise |=> (cnt == $past(reload)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 8,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              refTick,
  output logic              irqPulse
);
  tmr_cmd_t         cmd;
  logic [CNT_W-1:0] relData, cnt, reload;
  logic             wrap, reloadZero;

  tick_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_VALUE(CAL_VALUE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .refTick(refTick), .irqPulse(irqPulse), .cmd(cmd), .relData(relData),
    .cnt(cnt), .reload(reload), .wrap(wrap), .reloadZero(reloadZero)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .relData(relData),
    .cnt(cnt), .reload(reload), .wrap(wrap), .reloadZero(reloadZero)
  );
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, refTick = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        irqPulse;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state
  int unsigned mEn, mIe, mSrc, mFlag, mCnt, mRel, mIrq;

  always #5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .refTick(refTick), .irqPulse(irqPulse)
  );

  function automatic int unsigned expRead(input logic [7:0] a);
    case (a)
      8'h10: return mEn | (mIe << 1) | (mSrc << 2) | (mFlag << 16);
      8'h14: return mRel;
      8'h18: return mEn ? mCnt : 0;
      8'h1C: return 10000;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge(input bit w, input bit r, input logic [7:0] a,
                           input int unsigned d, input bit rf);
    bit tick, load, wrap;
    tick = (mEn != 0) && ((mSrc != 0) || rf);
    load = (w && a == 8'h10 && d[0] && mEn == 0) || (w && a == 8'h18 && mEn != 0);
    wrap = !load && tick && mCnt == 0;
    mIrq = (wrap && mIe != 0) ? 1 : 0;
    if (load)      mCnt = mRel;
    else if (tick) mCnt = (mCnt == 0) ? mRel : mCnt - 1;
    if (wrap) mFlag = 1;
    else if (r && a == 8'h10) mFlag = 0;
    else if (w && a == 8'h18) mFlag = 0;
    if (w && a == 8'h10) begin
      mEn = d[0]; mIe = d[1]; mSrc = d[2];
    end else if (wrap && mRel == 0) mEn = 0;
    if (w && a == 8'h14) mRel = d & 32'h00FF_FFFF;
  endtask

  // one clock: drive at negedge, check read before edge, check irq after edge
  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input int unsigned d, input bit rf, input string tag);
    @(negedge clk);
    regWrEn = w; regRdEn = r; regAddr = a; regWrData = d; refTick = rf;
    #1;
    if (r) check(tag, regRdData, expRead(a));
    @(posedge clk);
    #1;
    modelEdge(w, r, a, d, rf);
    check("R8 irq", irqPulse, mIrq);
  endtask

  task automatic idle(input int n, input bit rf);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h0, 0, rf, "idle");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, 1, a, 0, 0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input int unsigned d, input string tag);
    cyc(1, 0, a, d, 0, tag);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mEn = 0; mIe = 0; mSrc = 0; mFlag = 0; mCnt = 0; mRel = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 R4 R11 reset values and constants
    rd(8'h10, "R1 reset ctrl");
    rd(8'h14, "R4 reset reload");
    rd(8'h18, "R5 reset cur");
    rd(8'h1C, "R11 calib");
    rd(8'h20, "R11 unmapped");
    rd(8'h00, "R11 unmapped low");

    // R4 upper bits masked
    wr(8'h14, 32'hFFFF_FFFF, "R4");
    rd(8'h14, "R4 masked reload");
    // R5 disabled reads zero and counter idle
    idle(3, 1);
    rd(8'h18, "R5 disabled cur");

    // R2 control write with flag bit set does not set flag
    wr(8'h10, 32'h0001_0000, "R2");
    rd(8'h10, "R2 flag untouched");

    // R6 R7 R8 core clock, reload 3, irq on
    wr(8'h14, 3, "R7");
    wr(8'h10, 32'h7, "R5 enable");
    rd(8'h18, "R5 loaded value");
    for (int i = 0; i < 10; i++) rd(8'h18, "R7 count");
    rd(8'h10, "R3 flag seen");
    rd(8'h10, "R3 flag cleared");
    idle(9, 0);

    // R9 current write reloads and clears flag
    wr(8'h18, 32'h1234, "R9");
    rd(8'h10, "R9 flag cleared");
    rd(8'h18, "R9 reloaded");

    // R3 race: read ctrl on wrap edge; find the edge by probing
    for (int i = 0; i < 8; i++) rd(8'h10, "R3 race");
    // R9 race: current write every cycle keeps reloading
    for (int i = 0; i < 6; i++) wr(8'h18, 0, "R9 repeat");
    rd(8'h18, "R9 after repeats");

    // R6 reference tick source, irq off
    wr(8'h10, 32'h1, "R6");
    for (int i = 0; i < 20; i++) cyc(0, 1, 8'h18, 0, (i % 3) == 0, "R6 ref count");
    rd(8'h10, "R8 flag without irq");

    // R5 disable then re-enable reloads
    wr(8'h10, 32'h0, "R5 disable");
    rd(8'h18, "R5 disabled cur");
    wr(8'h14, 5, "R5");
    wr(8'h10, 32'h7, "R5 re-enable");
    rd(8'h18, "R5 reloaded on enable");

    // R10 one-shot with reload zero
    wr(8'h14, 0, "R10");
    idle(8, 0);
    rd(8'h10, "R10 enable cleared");
    rd(8'h18, "R10 cur zero");
    idle(4, 0);
    wr(8'h10, 32'h7, "R10 restart");
    for (int i = 0; i < 4; i++) rd(8'h10, "R10 stop again");

    // R10 control write on wrap edge keeps written enable
    wr(8'h10, 32'h7, "R10");
    wr(8'h10, 32'h3, "R10 write on wrap");
    rd(8'h10, "R10 write wins");
    idle(3, 0);
    rd(8'h10, "R10 final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule